// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Channel

This block is one channel of a timer array. It holds a 16-bit reload value and a 16-bit counter. The counter runs as a periodic down-counter, an up/down event counter, a retriggerable-when-idle one-shot or a fixed-period PWM generator. A two-bit mode field selects the mode. The channel drives a single output pin (`tmr_out`) and produces a one-cycle overflow pulse (`ovf_pulse`) that neighbouring channels can count.

Software reaches the channel through a byte-wide register port. The port has three locations: the reload/counter low byte, the reload/counter high byte and a control byte. A write takes effect at the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`. The interface has no back-pressure: every write is accepted in its cycle, so it needs no valid/ready handshake. The other pins are plain level or single-cycle controls. The prescaled clock enables arrive from outside on `tick_en`.

Top module: `mmt_channel`

## Requirements
- R1: After reset the counter, reload value, control byte, `tmr_out` and `ovf_pulse` are all 0. Address 0 reads the counter low byte and address 1 reads the counter high byte. Address 2 reads the control byte, which holds mode in bits [1:0] (00 periodic, 01 event, 10 one-shot, 11 PWM), edge polarity in bit 2 (1 = falling), event source in bit 3 (1 = neighbour overflow) and clock select in bits [7:6]. Bits [5:4] read 0. Address 3 reads 0.
- R2: While `cnt_start` is low the counter changes only through register writes.
- R3: Writing address 0 or 1 sets that byte of the reload value. While `cnt_start` is low the write also sets the same byte of the counter. While `cnt_start` is high the counter keeps counting and takes the new value at its next reload.
- R4: In periodic mode each tick decrements the counter. A tick that finds the counter at 0 instead loads the reload value, toggles `tmr_out` and raises `ovf_pulse` for one cycle.
- R5: Outside event mode a tick is `tick_en[sel]`, where sel is control bits [7:6]. Index 0 is the undivided clock, 1 is divide by 8, 2 is divide by 32 and 3 is the slow clock divided by 32.
- R6: In event mode a tick is one of two things. With bit 3 set it is `nbr_ovf`. With bit 3 clear it is an edge of `ext_in` of the selected polarity, compared with the previous cycle's sample. The counter counts up when `count_up` is 1 and down when it is 0.
- R7: In event mode a tick that finds the counter at 0xFFFF counting up, or at 0 counting down, loads the reload value, toggles `tmr_out` and pulses `ovf_pulse`.
- R8: In one-shot mode an `os_trig` while running and idle loads the reload value, drives `tmr_out` high and starts the shot. A trigger during a shot is ignored. Each tick decrements the counter. A tick that finds it at 1 or 0 sets it to 0, drives `tmr_out` low, pulses `ovf_pulse` and ends the shot.
- R9: In PWM mode the period is 65536 ticks. A tick at counter 0 is the boundary: it sets the counter to 0xFFFF, latches the reload value as the width, and pulses `ovf_pulse`. `tmr_out` is high for the first width ticks of each period, so a width change waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| cnt_start | input | 1 | Run enable for this channel |
| count_up | input | 1 | Event mode direction, 1 = up |
| tick_en | input | 4 | Prescaled clock enables |
| ext_in | input | 1 | External event pin |
| nbr_ovf | input | 1 | Overflow pulse of a neighbouring channel |
| os_trig | input | 1 | One-shot trigger |
| tmr_out | output | 1 | Timer output pin |
| ovf_pulse | output | 1 | One-cycle overflow/underflow pulse |

## Verification
The counter, `tmr_out` and `ovf_pulse` respond at the first clock edge after the tick, trigger or write that causes the change. `reg_rdata` follows `reg_addr` in the same cycle. An external edge is seen in the cycle the pin differs from the sample taken at the previous edge. The bench changes inputs one time unit after each rising edge and advances its reference model at that edge. It compares every output at the falling edge, so each check sees exactly one register stage of latency. A PWM width change is checked across a full 65536-tick boundary.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MD_PERIODIC = 2'b00,
    MD_EVENT    = 2'b01,
    MD_ONESHOT  = 2'b10,
    MD_PWM      = 2'b11
  } tmr_mode_e;

  localparam int NSRC = 4;
  localparam int SELW = $clog2(NSRC);

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  typedef struct packed {
    logic [SELW-1:0] csel;
    logic            evsrc;
    logic            pol;
    tmr_mode_e       mode;
  } ctrl_t;
endpackage

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [CW/2-1:0] wdata,
  input  logic [CW-1:0]   cnt,
  output ctrl_t           ctrl,
  output logic [CW-1:0]   reload,
  output logic            ld_lo,
  output logic            ld_hi,
  output logic [CW/2-1:0] rdata
);
  localparam int DW = CW / 2;

  assign ld_lo = wr_en && (addr == A_LO);
  assign ld_hi = wr_en && (addr == A_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
      ctrl   <= '0;
    end else begin
      if (ld_lo) reload[DW-1:0]  <= wdata;
      if (ld_hi) reload[CW-1:DW] <= wdata;
      if (wr_en && addr == A_CTRL) begin
        ctrl.mode  <= tmr_mode_e'(wdata[1:0]);
        ctrl.pol   <= wdata[2];
        ctrl.evsrc <= wdata[3];
        ctrl.csel  <= wdata[DW-1 -: SELW];
      end
    end
  end

  always_comb begin
    case (addr)
      A_LO:    rdata = cnt[DW-1:0];
      A_HI:    rdata = cnt[CW-1:DW];
      A_CTRL:  rdata = {ctrl.csel, {(DW-SELW-4){1'b0}}, ctrl.evsrc, ctrl.pol, ctrl.mode};
      default: rdata = '0;
    endcase
  end

  // R1: a control write shows up on the read port one edge later
  p_ctrl_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> (ctrl.mode == tmr_mode_e'($past(wdata[1:0]))));
endmodule

// File: rtl/mmt_src.sv
module mmt_src
  import mmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_en,
  input  ctrl_t           ctrl,
  input  logic            ext_in,
  input  logic            nbr_ovf,
  output logic            step
);
  logic ext_q;
  logic edge_r, edge_f, ev_tick, clk_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_in;
  end

  assign edge_r   = ext_in & ~ext_q;
  assign edge_f   = ~ext_in & ext_q;
  assign ev_tick  = ctrl.evsrc ? nbr_ovf : (ctrl.pol ? edge_f : edge_r);
  assign clk_tick = tick_en[ctrl.csel];
  assign step     = (ctrl.mode == MD_EVENT) ? ev_tick : clk_tick;

  // R6: with the pin as source, a step in event mode needs a pin change
  p_pin_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MD_EVENT && !ctrl.evsrc && step) |-> (ext_in != ext_q));
endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            step,
  input  logic            up_dn,
  input  logic            trig,
  input  tmr_mode_e       mode,
  input  logic [CW-1:0]   reload,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [CW/2-1:0] wdata,
  output logic [CW-1:0]   cnt,
  output logic            tout,
  output logic            ovf
);
  localparam int          DW   = CW / 2;
  localparam logic [CW-1:0] ALL1 = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          busy;
  logic [CW-1:0] wid;
  logic [CW-1:0] cnt_dec;

  assign cnt_dec = cnt - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tout <= 1'b0;
      ovf  <= 1'b0;
      busy <= 1'b0;
      wid  <= '0;
    end else begin
      ovf <= 1'b0;
      if (mode != MD_ONESHOT) busy <= 1'b0;
      if (!start) begin
        if (ld_lo) cnt[DW-1:0]  <= wdata;
        if (ld_hi) cnt[CW-1:DW] <= wdata;
      end else begin
        case (mode)
          MD_PERIODIC: if (step) begin
            if (cnt == '0) begin
              cnt  <= reload;
              ovf  <= 1'b1;
              tout <= ~tout;
            end else cnt <= cnt_dec;
          end
          MD_EVENT: if (step) begin
            if (up_dn ? (cnt == ALL1) : (cnt == '0)) begin
              cnt  <= reload;
              ovf  <= 1'b1;
              tout <= ~tout;
            end else cnt <= up_dn ? cnt + ONE : cnt_dec;
          end
          MD_ONESHOT: begin
            if (trig && !busy) begin
              cnt  <= reload;
              tout <= 1'b1;
              busy <= 1'b1;
            end else if (busy && step) begin
              if (cnt <= ONE) begin
                cnt  <= '0;
                tout <= 1'b0;
                ovf  <= 1'b1;
                busy <= 1'b0;
              end else cnt <= cnt_dec;
            end
          end
          default: if (step) begin
            if (cnt == '0) begin
              cnt  <= ALL1;
              wid  <= reload;
              tout <= (reload != '0);
              ovf  <= 1'b1;
            end else begin
              cnt  <= cnt_dec;
              tout <= (~cnt_dec) < wid;
            end
          end
        endcase
      end
    end
  end

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !ld_lo && !ld_hi) |=> $stable(cnt));

  p_periodic_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && step && mode == MD_PERIODIC && cnt != '0) |=> (cnt == $past(cnt) - ONE) && !ovf);

  p_event_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && step && mode == MD_EVENT && up_dn && cnt == ALL1) |=> ovf && (cnt == $past(reload)));

  p_oneshot_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && $past(mode) == MD_ONESHOT) |-> !tout && (cnt == '0));
endmodule

// File: rtl/mmt_channel.sv
module mmt_channel
  import mmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cnt_start,
  input  logic       count_up,
  input  logic [3:0] tick_en,
  input  logic       ext_in,
  input  logic       nbr_ovf,
  input  logic       os_trig,
  output logic       tmr_out,
  output logic       ovf_pulse
);
  localparam int CW = 16;

  ctrl_t         ctrl;
  logic [CW-1:0] reload, cnt;
  logic          ld_lo, ld_hi, step;

  mmt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt), .ctrl(ctrl), .reload(reload), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .rdata(reg_rdata)
  );

  mmt_src u_src (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl(ctrl),
    .ext_in(ext_in), .nbr_ovf(nbr_ovf), .step(step)
  );

  mmt_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .start(cnt_start), .step(step), .up_dn(count_up),
    .trig(os_trig), .mode(ctrl.mode), .reload(reload), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .wdata(reg_wdata), .cnt(cnt), .tout(tmr_out), .ovf(ovf_pulse)
  );
endmodule

// File: tb/tb_mmt_channel.sv
module tb_mmt_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       cnt_start = 1'b0;
  logic       count_up = 1'b0;
  logic [3:0] tick_en = 4'd0;
  logic       ext_in = 1'b0;
  logic       nbr_ovf = 1'b0;
  logic       os_trig = 1'b0;
  logic       tmr_out, ovf_pulse;

  mmt_channel dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, live = 0;
  bit rnd_ext = 0, rnd_nbr = 0, rnd_trig = 0;
  string ph_tag = "R4";

  // reference model state
  int  m_cnt, m_rel, m_wid, m_mode, m_sel;
  bit  m_pol, m_src, m_tout, m_ovf, m_busy, m_extq;
  int  n_cnt, n_wid;
  bit  n_tout, n_ovf, n_busy, ev, st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_wid = 0; m_mode = 0; m_sel = 0;
      m_pol = 0; m_src = 0; m_tout = 0; m_ovf = 0; m_busy = 0; m_extq = 0;
    end else begin
      ev = m_src ? nbr_ovf : (m_pol ? (!ext_in && m_extq) : (ext_in && !m_extq));
      st = (m_mode == 1) ? ev : tick_en[m_sel];
      n_cnt = m_cnt; n_wid = m_wid; n_tout = m_tout; n_ovf = 0;
      n_busy = (m_mode != 2) ? 0 : m_busy;
      if (!cnt_start) begin
        if (reg_wr && reg_addr == 0) n_cnt = (m_cnt & 'hFF00) | reg_wdata;
        if (reg_wr && reg_addr == 1) n_cnt = (m_cnt & 'h00FF) | (reg_wdata << 8);
      end else if (m_mode == 0 && st) begin
        if (m_cnt == 0) begin n_cnt = m_rel; n_ovf = 1; n_tout = !m_tout; end
        else n_cnt = m_cnt - 1;
      end else if (m_mode == 1 && st) begin
        if ((count_up && m_cnt == 'hFFFF) || (!count_up && m_cnt == 0)) begin
          n_cnt = m_rel; n_ovf = 1; n_tout = !m_tout;
        end else n_cnt = count_up ? m_cnt + 1 : m_cnt - 1;
      end else if (m_mode == 2) begin
        if (os_trig && !m_busy) begin n_cnt = m_rel; n_tout = 1; n_busy = 1; end
        else if (m_busy && st) begin
          if (m_cnt <= 1) begin n_cnt = 0; n_tout = 0; n_ovf = 1; n_busy = 0; end
          else n_cnt = m_cnt - 1;
        end
      end else if (m_mode == 3 && st) begin
        if (m_cnt == 0) begin
          n_cnt = 'hFFFF; n_wid = m_rel; n_tout = (m_rel != 0); n_ovf = 1;
        end else begin
          n_cnt = m_cnt - 1; n_tout = (65535 - n_cnt) < m_wid;
        end
      end
      if (reg_wr && reg_addr == 0) m_rel = (m_rel & 'hFF00) | reg_wdata;
      if (reg_wr && reg_addr == 1) m_rel = (m_rel & 'h00FF) | (reg_wdata << 8);
      if (reg_wr && reg_addr == 2) begin
        m_mode = reg_wdata[1:0]; m_pol = reg_wdata[2]; m_src = reg_wdata[3];
        m_sel = reg_wdata[7:6];
      end
      m_cnt = n_cnt; m_wid = n_wid; m_tout = n_tout; m_ovf = n_ovf; m_busy = n_busy;
      m_extq = ext_in;
    end
  end

  function automatic string mode_tag();
    case (m_mode)
      0: return "R4";
      1: return "R6";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_rd();
    case (reg_addr)
      2'd0: return m_cnt & 'hFF;
      2'd1: return (m_cnt >> 8) & 'hFF;
      2'd2: return (m_sel << 6) | (int'(m_src) << 3) | (int'(m_pol) << 2) | m_mode;
      default: return 0;
    endcase
  endfunction

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (live) begin
      check({mode_tag(), "/", ph_tag}, tmr_out, m_tout, "tmr_out");
      check({mode_tag(), "/", ph_tag}, ovf_pulse, m_ovf, "ovf_pulse");
      check((reg_addr == 2) ? "R1" : {"R3/", ph_tag}, reg_rdata, exp_rd(), "reg_rdata");
    end
  end

  task automatic gen();
    cyc++;
    tick_en = {cyc % 100 == 0, cyc % 32 == 0, cyc % 8 == 0, 1'b1};
    if (rnd_ext)  ext_in  = $urandom_range(0, 1);
    if (rnd_nbr)  nbr_ovf = ($urandom_range(0, 3) == 0);
    os_trig = rnd_trig && ($urandom_range(0, 9) == 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reg_wr = 1'b0;
      reg_addr = 2'(i % 3);
      gen();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    gen();
  endtask

  initial begin
    // R1: reset state
    #5;
    reg_addr = 2'd0; #1; check("R1", reg_rdata, 0, "cnt lo at reset");
    reg_addr = 2'd1; #1; check("R1", reg_rdata, 0, "cnt hi at reset");
    reg_addr = 2'd2; #1; check("R1", reg_rdata, 0, "ctrl at reset");
    check("R1", tmr_out, 0, "tmr_out at reset");
    check("R1", ovf_pulse, 0, "ovf at reset");
    @(posedge clk); #1; rst_n = 1'b1; live = 1;

    // R4 periodic, reload loaded while stopped (R3)
    ph_tag = "R3"; wr(0, 8'd5); wr(1, 8'd0); wr(2, 8'h00);
    run(3);
    cnt_start = 1; ph_tag = "R4"; run(40);
    ph_tag = "R3"; wr(0, 8'd3); run(30);        // running write: counter untouched
    ph_tag = "R5"; wr(2, 8'h40); run(120);       // divide-by-8 source
    wr(2, 8'h80); run(130);                      // divide-by-32 source
    ph_tag = "R2"; cnt_start = 0; run(20);       // stopped: counter frozen

    // R6/R7 event mode
    ph_tag = "R7"; wr(0, 8'hFD); wr(1, 8'hFF); wr(2, 8'h01);
    count_up = 1; cnt_start = 1; rnd_ext = 1; run(60);
    ph_tag = "R6"; wr(2, 8'h05); run(60);        // falling edges
    rnd_ext = 0; rnd_nbr = 1; wr(2, 8'h09); run(60);
    ph_tag = "R7"; count_up = 0; wr(0, 8'd2); wr(1, 8'd0); run(60);
    rnd_nbr = 0; nbr_ovf = 0;

    // R8 one-shot
    ph_tag = "R8"; cnt_start = 0; wr(0, 8'd4); wr(2, 8'h02);
    cnt_start = 1; rnd_trig = 1; run(120);
    wr(0, 8'd0); run(60);
    rnd_trig = 0; cnt_start = 0; run(5);

    // R9 PWM across two period boundaries, width change mid-period
    ph_tag = "R9"; wr(0, 8'd7); wr(1, 8'd0); wr(2, 8'h03);
    cnt_start = 1; run(40000);
    wr(0, 8'd20); run(95000);
    wr(0, 8'd0); run(40000);

    done = 1; live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected done at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule